// File: doc/BRIEF.md
# Root Hub Port Status and Control

This block keeps the status/control word of a single USB 2.0 root hub port and the small state machine behind it. It tracks device attach and detach, enables the port only at the end of a bus reset that found a high-speed device, and runs suspend and resume. It watches over-current and controls the power switch. It also handles port ownership, which can pass between this controller and a companion full/low-speed controller.

Software writes the whole word in one cycle. Status bits that hardware sets are cleared by writing a one to them. Some bits can only be set by hardware, and some writes are ignored. The outputs are the current word, a one-cycle port-change pulse for the global status logic, and levels that ask the bus side to drive reset, resume or suspend, or to enter a test mode. The analog signalling and the timing of reset and resume on the wire are handled elsewhere.

Top module: `root_port_ctrl`

## Requirements
- R1: Bit 0 (connected) shows `connect_i` one cycle later while powered. Bit 1 (connect changed) is set in the cycle after any difference between `connect_i` and bit 0, even if bit 1 is already set. A write with bit 1 = 1 clears it.
- R2: Writing 1 to bit 2 (enabled) has no effect, and writing 0 disables the port. Bit 2 goes high only on the write that clears bit 8 (port reset), and only if `hs_detect_i` and `connect_i` are both 1 at that write. A write that sets bit 8 clears bit 2.
- R3: When `connect_i` is 0 while the port is enabled, bit 2 clears and bit 3 (enable changed) sets on the next edge. A disable done by software does not set bit 3. A write with bit 3 = 1 clears bit 3.
- R4: A write with bit 7 (suspend) = 1 suspends an enabled port, and a write of 0 to bit 7 is ignored. Bit 7 clears when bit 6 (resume) falls, when bit 8 rises, or when the port is disabled.
- R5: `resume_jk_i` while suspended (bits 2 and 7 set, bit 6 clear) sets bit 6 and pulses `port_change_o` in the same cycle. Setting bit 6 by a write gives no pulse.
- R6: Bit 13 (owner) is 1 after reset and on every edge where `cfg_flag_i` is 0. It goes to 0 on the edge where `cfg_flag_i` rises. Otherwise a write loads it from bit 13 of the data.
- R7: Bit 12 (power) is set and cleared by writes. While bit 12 is 0, bits 0, 1, 2, 3, 6, 7, 8, 11 and 10 read 0 and the port ignores attach.
- R8: Bit 4 (over-current active) shows `over_current_i` one cycle later. Bit 5 is set on any change of it and is cleared by writing 1. A rising over-current removes power (bit 12 goes to 0).
- R9: Bits 11:10 show the line state sampled one cycle earlier, D+ on bit 11 and D- on bit 10. So a K state (D+ = 0, D- = 1) reads as 01.
- R10: Bits 19:16 select the test mode: 0 is none, 1 J, 2 K, 3 SE0_NAK, 4 packet, 5 force-enable. A write with a value from 6 to 15 leaves the field unchanged. The field is also driven on `test_mode_o`.
- R11: `port_change_o` is a one-cycle pulse in the cycle where bit 1, 3 or 5 goes from 0 to 1, or where hardware sets bit 6. It fires only while bit 13 was 0.
- R12: `drv_reset_o`, `drv_resume_o` and `drv_suspend_o` follow bits 8, 6 and 7 of the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the status/control word |
| wr_data_i | input | 32 | Write data |
| connect_i | input | 1 | Device attached indication |
| line_state_i | input | 2 | Line state, [1] = D+, [0] = D- |
| hs_detect_i | input | 1 | High-speed device found by the bus reset |
| over_current_i | input | 1 | Over-current sense |
| resume_jk_i | input | 1 | J-to-K transition seen on the bus |
| cfg_flag_i | input | 1 | Global configure flag |
| port_reg_o | output | 32 | Status/control word |
| port_change_o | output | 1 | Port-change pulse |
| drv_reset_o | output | 1 | Request to drive bus reset |
| drv_resume_o | output | 1 | Request to drive resume signalling |
| drv_suspend_o | output | 1 | Port suspended, downstream traffic blocked |
| test_mode_o | output | 4 | Selected test mode |

## Verification
Directed sequences go through attach, reset with and without a high-speed device, suspend followed by a hardware or a software resume, disconnect while enabled, and over-current rise and fall. They show that hardware-only sets differ from the writes that are ignored. Ownership is flipped by writes and by configure-flag edges, which separates a change pulse that is suppressed from a status bit that is still set. A long random phase mixes write data that is mostly powered and enabled with slowly toggling inputs. Every word and pulse is compared against a bench model, which catches bad priority between hardware sets and write-one-to-clear in the same cycle.

// File: rtl/root_port_pkg.sv
package root_port_pkg;
  localparam int REG_W    = 32;
  localparam int B_CONN   = 0;
  localparam int B_CCHG   = 1;
  localparam int B_EN     = 2;
  localparam int B_ECHG   = 3;
  localparam int B_OCA    = 4;
  localparam int B_OCC    = 5;
  localparam int B_RES    = 6;
  localparam int B_SUSP   = 7;
  localparam int B_PRST   = 8;
  localparam int B_LS_LO  = 10;
  localparam int LS_W     = 2;
  localparam int B_PWR    = 12;
  localparam int B_OWN    = 13;
  localparam int B_TST_LO = 16;
  localparam int TST_W    = 4;
  localparam int TST_MAX  = 5;
  localparam int N_CHG    = 3;
  localparam int CHG_CONN = 0;
  localparam int CHG_EN   = 1;
  localparam int CHG_OC   = 2;
endpackage

// File: rtl/rp_chg_bits.sv
module rp_chg_bits #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] kill_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o,
  output logic [N-1:0] rise_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q_q, q_n;
    // hardware set wins over write-one-to-clear
    assign q_n       = kill_i[i] ? 1'b0 : (set_i[i] | (q_q & ~clr_i[i]));
    assign rise_o[i] = q_n & ~q_q;
    assign q_o[i]    = q_q;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) q_q <= 1'b0;
      else         q_q <= q_n;

    assert_chg_sticky_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i[i] && !kill_i[i]) |=> q_o[i]);
  end
endmodule

// File: rtl/rp_link.sv
module rp_link #(
  parameter int LS_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pwr_i,
  input  logic            wr_i,
  input  logic            wd_en_i,
  input  logic            wd_susp_i,
  input  logic            wd_res_i,
  input  logic            wd_prst_i,
  input  logic            connect_i,
  input  logic            hs_detect_i,
  input  logic            resume_jk_i,
  input  logic [LS_W-1:0] line_state_i,
  output logic            conn_o,
  output logic            conn_diff_o,
  output logic            fault_o,
  output logic            en_o,
  output logic            susp_o,
  output logic            res_o,
  output logic            prst_o,
  output logic [LS_W-1:0] ls_o,
  output logic            jk_set_o
);
  logic conn_q, en_q, susp_q, res_q, prst_q;
  logic conn_n, en_n, susp_n, res_n, prst_n;
  logic [LS_W-1:0] ls_q, ls_n;
  logic prst_rise, prst_fall, res_fall, jk;

  assign prst_rise   = wr_i & wd_prst_i & ~prst_q;
  assign prst_fall   = wr_i & ~wd_prst_i & prst_q;
  assign conn_diff_o = pwr_i & (connect_i != conn_q);
  assign fault_o     = pwr_i & en_q & ~connect_i;
  assign jk          = pwr_i & resume_jk_i & susp_q & en_q & ~res_q;

  always_comb begin
    conn_n = pwr_i & connect_i;
    ls_n   = pwr_i ? line_state_i : '0;
    prst_n = pwr_i & (wr_i ? wd_prst_i : prst_q);

    if (!pwr_i || prst_rise)    en_n = 1'b0;
    else if (prst_fall)         en_n = hs_detect_i & connect_i;
    else if (fault_o)           en_n = 1'b0;
    else if (wr_i && !wd_en_i)  en_n = 1'b0;
    else                        en_n = en_q;

    if (!pwr_i)    res_n = 1'b0;
    else if (jk)   res_n = 1'b1;
    else if (wr_i) res_n = wd_res_i;
    else           res_n = res_q;
    res_fall = res_q & ~res_n;

    if (!pwr_i || prst_rise || res_fall || !en_n) susp_n = 1'b0;
    else if (wr_i && wd_susp_i)                   susp_n = 1'b1;
    else                                          susp_n = susp_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      conn_q <= 1'b0; en_q <= 1'b0; susp_q <= 1'b0;
      res_q  <= 1'b0; prst_q <= 1'b0; ls_q <= '0;
    end else begin
      conn_q <= conn_n; en_q <= en_n; susp_q <= susp_n;
      res_q  <= res_n;  prst_q <= prst_n; ls_q <= ls_n;
    end

  assign conn_o   = conn_q;
  assign en_o     = en_q;
  assign susp_o   = susp_q;
  assign res_o    = res_q;
  assign prst_o   = prst_q;
  assign ls_o     = ls_q;
  assign jk_set_o = jk;

  assert_en_from_reset_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_q) |-> ($past(prst_q) && !prst_q));
  assert_susp_exit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(susp_q) |-> (!en_q || prst_q || ($past(res_q) && !res_q) || !$past(pwr_i)));
  assert_jk_resume_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jk_set_o |=> res_q);
endmodule

// File: rtl/rp_owner.sv
module rp_owner (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cfg_i,
  input  logic wr_i,
  input  logic wd_own_i,
  output logic own_o
);
  logic cfg_q, own_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cfg_q <= 1'b0;
      own_q <= 1'b1;
    end else begin
      cfg_q <= cfg_i;
      if (!cfg_i)      own_q <= 1'b1;
      else if (!cfg_q) own_q <= 1'b0;
      else if (wr_i)   own_q <= wd_own_i;
    end
  assign own_o = own_q;

  assert_own_cfg_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i |=> own_q);
  assert_own_cfg_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i && !cfg_q) |=> !own_q);
endmodule

// File: rtl/root_port_ctrl.sv
module root_port_ctrl
  import root_port_pkg::*;
#(
  parameter bit PWR_SWITCH = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             connect_i,
  input  logic [LS_W-1:0]  line_state_i,
  input  logic             hs_detect_i,
  input  logic             over_current_i,
  input  logic             resume_jk_i,
  input  logic             cfg_flag_i,
  output logic [REG_W-1:0] port_reg_o,
  output logic             port_change_o,
  output logic             drv_reset_o,
  output logic             drv_resume_o,
  output logic             drv_suspend_o,
  output logic [TST_W-1:0] test_mode_o
);
  logic pp, oc_q, own, pcd_q;
  logic conn, conn_diff, fault, en, susp, res, prst, jk_set;
  logic [LS_W-1:0]  ls;
  logic [TST_W-1:0] tst_q, wd_tst;
  logic [N_CHG-1:0] chg_set, chg_clr, chg_kill, chg_q, chg_rise;
  logic oc_rise;

  assign oc_rise = over_current_i & ~oc_q;
  assign wd_tst  = wr_data_i[B_TST_LO +: TST_W];

  if (PWR_SWITCH) begin : g_pwr_sw
    logic pp_q;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)      pp_q <= 1'b0;
      else if (oc_rise) pp_q <= 1'b0;
      else if (wr_en_i) pp_q <= wr_data_i[B_PWR];
    assign pp = pp_q;
    assert_oc_cuts_power_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (over_current_i && !oc_q) |=> !pp_q);
  end else begin : g_pwr_fixed
    assign pp = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      oc_q  <= 1'b0;
      tst_q <= '0;
      pcd_q <= 1'b0;
    end else begin
      oc_q  <= over_current_i;
      if (wr_en_i && (int'(wd_tst) <= TST_MAX)) tst_q <= wd_tst;
      pcd_q <= ~own & ((|chg_rise) | jk_set);
    end

  rp_link #(.LS_W(LS_W)) u_link (
    .clk_i, .rst_ni,
    .pwr_i        (pp),
    .wr_i         (wr_en_i),
    .wd_en_i      (wr_data_i[B_EN]),
    .wd_susp_i    (wr_data_i[B_SUSP]),
    .wd_res_i     (wr_data_i[B_RES]),
    .wd_prst_i    (wr_data_i[B_PRST]),
    .connect_i, .hs_detect_i, .resume_jk_i, .line_state_i,
    .conn_o       (conn),
    .conn_diff_o  (conn_diff),
    .fault_o      (fault),
    .en_o         (en),
    .susp_o       (susp),
    .res_o        (res),
    .prst_o       (prst),
    .ls_o         (ls),
    .jk_set_o     (jk_set)
  );

  assign chg_set[CHG_CONN]  = conn_diff;
  assign chg_set[CHG_EN]    = fault;
  assign chg_set[CHG_OC]    = over_current_i ^ oc_q;
  assign chg_clr[CHG_CONN]  = wr_en_i & wr_data_i[B_CCHG];
  assign chg_clr[CHG_EN]    = wr_en_i & wr_data_i[B_ECHG];
  assign chg_clr[CHG_OC]    = wr_en_i & wr_data_i[B_OCC];
  assign chg_kill[CHG_CONN] = ~pp;
  assign chg_kill[CHG_EN]   = ~pp;
  assign chg_kill[CHG_OC]   = 1'b0;

  rp_chg_bits #(.N(N_CHG)) u_chg (
    .clk_i, .rst_ni,
    .kill_i (chg_kill),
    .set_i  (chg_set),
    .clr_i  (chg_clr),
    .q_o    (chg_q),
    .rise_o (chg_rise)
  );

  rp_owner u_own (
    .clk_i, .rst_ni,
    .cfg_i    (cfg_flag_i),
    .wr_i     (wr_en_i),
    .wd_own_i (wr_data_i[B_OWN]),
    .own_o    (own)
  );

  always_comb begin
    port_reg_o                     = '0;
    port_reg_o[B_CONN]             = pp & conn;
    port_reg_o[B_CCHG]             = pp & chg_q[CHG_CONN];
    port_reg_o[B_EN]               = pp & en;
    port_reg_o[B_ECHG]             = pp & chg_q[CHG_EN];
    port_reg_o[B_OCA]              = oc_q;
    port_reg_o[B_OCC]              = chg_q[CHG_OC];
    port_reg_o[B_RES]              = pp & res;
    port_reg_o[B_SUSP]             = pp & susp;
    port_reg_o[B_PRST]             = pp & prst;
    port_reg_o[B_LS_LO +: LS_W]    = pp ? ls : '0;
    port_reg_o[B_PWR]              = pp;
    port_reg_o[B_OWN]              = own;
    port_reg_o[B_TST_LO +: TST_W]  = tst_q;
  end

  assign port_change_o = pcd_q;
  assign drv_reset_o   = pp & prst;
  assign drv_resume_o  = pp & res;
  assign drv_suspend_o = pp & susp;
  assign test_mode_o   = tst_q;

  logic unused_wd;
  assign unused_wd = ^{wr_data_i[REG_W-1:B_TST_LO+TST_W], wr_data_i[15:14],
                       wr_data_i[11:9], wr_data_i[B_OCA], wr_data_i[B_CONN],
                       wr_data_i[B_PWR]};

  assert_pcd_owner_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_change_o |-> !$past(own));
  assert_test_reserved_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (int'(wd_tst) > TST_MAX)) |=> $stable(tst_q));
  assert_oc_follow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (oc_q == $past(over_current_i)));
endmodule

// File: tb/root_port_ctrl_tb.sv
module root_port_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0; logic [31:0] wr_data = '0;
  logic connect = 1'b0, hs = 1'b0, oc = 1'b0, jk = 1'b0, cfg = 1'b0;
  logic [1:0] ls = 2'b00;
  logic [31:0] port_reg; logic pcd, d_rst, d_res, d_susp; logic [3:0] tmode;
  int n_chk = 0, n_fail = 0; bit done = 0;

  always #2 clk = ~clk;

  root_port_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .connect_i(connect), .line_state_i(ls), .hs_detect_i(hs),
    .over_current_i(oc), .resume_jk_i(jk), .cfg_flag_i(cfg),
    .port_reg_o(port_reg), .port_change_o(pcd), .drv_reset_o(d_rst),
    .drv_resume_o(d_res), .drv_suspend_o(d_susp), .test_mode_o(tmode));

  // bench model of the requirements
  logic m_pp, m_conn, m_cc, m_en, m_ec, m_oca, m_occ, m_res, m_susp, m_prst, m_own, m_cfg, m_pcd;
  logic [1:0] m_ls; logic [3:0] m_tst;

  function automatic logic [31:0] m_word();
    logic [31:0] r = '0;
    r[0] = m_pp & m_conn; r[1] = m_pp & m_cc; r[2] = m_pp & m_en; r[3] = m_pp & m_ec;
    r[4] = m_oca; r[5] = m_occ; r[6] = m_pp & m_res; r[7] = m_pp & m_susp;
    r[8] = m_pp & m_prst; r[11:10] = m_pp ? m_ls : 2'b00; r[12] = m_pp; r[13] = m_own;
    r[19:16] = m_tst;
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    logic p, prise, pfall, flt, k, n_en, n_res, n_susp, n_cc, n_ec, n_occ;
    if (!rst_n) begin
      {m_pp, m_conn, m_cc, m_en, m_ec, m_oca, m_occ, m_res, m_susp, m_prst, m_cfg, m_pcd} <= '0;
      m_own <= 1'b1; m_ls <= '0; m_tst <= '0;
    end else begin
      p     = m_pp;
      prise = wr_en & wr_data[8] & ~m_prst;
      pfall = wr_en & ~wr_data[8] & m_prst;
      flt   = p & m_en & ~connect;
      k     = p & jk & m_susp & m_en & ~m_res;
      if (!p || prise) n_en = 0;
      else if (pfall) n_en = hs & connect;
      else if (flt) n_en = 0;
      else if (wr_en && !wr_data[2]) n_en = 0;
      else n_en = m_en;
      if (!p) n_res = 0; else if (k) n_res = 1; else if (wr_en) n_res = wr_data[6]; else n_res = m_res;
      if (!p || prise || (m_res && !n_res) || !n_en) n_susp = 0;
      else if (wr_en && wr_data[7]) n_susp = 1; else n_susp = m_susp;
      n_cc  = p & ((connect != m_conn) | (m_cc & ~(wr_en & wr_data[1])));
      n_ec  = p & (flt | (m_ec & ~(wr_en & wr_data[3])));
      n_occ = (oc != m_oca) | (m_occ & ~(wr_en & wr_data[5]));
      m_pcd  <= ~m_own & ((n_cc & ~m_cc) | (n_ec & ~m_ec) | (n_occ & ~m_occ) | k);
      m_cc <= n_cc; m_ec <= n_ec; m_occ <= n_occ;
      m_en <= n_en; m_res <= n_res; m_susp <= n_susp;
      m_conn <= p & connect; m_ls <= p ? ls : 2'b00;
      m_prst <= p & (wr_en ? wr_data[8] : m_prst);
      m_oca <= oc;
      if (oc && !m_oca) m_pp <= 0; else if (wr_en) m_pp <= wr_data[12];
      if (wr_en && wr_data[19:16] <= 4'd5) m_tst <= wr_data[19:16];
      m_cfg <= cfg;
      if (!cfg) m_own <= 1; else if (!m_cfg) m_own <= 0; else if (wr_en) m_own <= wr_data[13];
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d; step(); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic model_cmp();
    check("MODEL word", port_reg, m_word());
    check("MODEL R11 change pulse", {31'd0, pcd}, {31'd0, m_pcd});
    check("MODEL R12 bus requests", {29'd0, d_rst, d_res, d_susp}, {29'd0, m_word()[8], m_word()[6], m_word()[7]});
    check("MODEL R10 test output", {28'd0, tmode}, {28'd0, m_word()[19:16]});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1; @(negedge clk);
    check("R6 reset word", port_reg, 32'h0000_2000);
    check("R11 reset pulse", {31'd0, pcd}, 32'd0);
    cfg = 1; step(); step();
    check("R6 owner cleared on cfg rise", {31'd0, port_reg[13]}, 32'd0);
    connect = 1; step(); step();
    check("R7 no attach while unpowered", port_reg & 32'h3, 32'h0);
    wr(32'h1000); step();
    check("R1 connect and change", port_reg & 32'h3, 32'h3);
    check("R11 pulse on connect change", {31'd0, pcd}, 32'd1);
    step();
    check("R11 pulse lasts one cycle", {31'd0, pcd}, 32'd0);
    wr(32'h1002);
    check("R1 W1C clears connect change", {31'd0, port_reg[1]}, 32'd0);
    wr(32'h1004);
    check("R2 software cannot enable", {31'd0, port_reg[2]}, 32'd0);
    wr(32'h1104);
    check("R12 reset request", {31'd0, d_rst}, 32'd1);
    hs = 1; wr(32'h1004); hs = 0;
    check("R2 enabled after high-speed reset", port_reg & 32'h104, 32'h004);
    wr(32'h1084);
    check("R4 suspend set", {30'd0, port_reg[7], d_susp}, 32'd3);
    wr(32'h1004);
    check("R4 write zero to suspend ignored", {31'd0, port_reg[7]}, 32'd1);
    jk = 1; step(); jk = 0;
    check("R5 J-K sets resume", {31'd0, port_reg[6]}, 32'd1);
    check("R5 J-K pulses change", {31'd0, pcd}, 32'd1);
    wr(32'h1004);
    check("R4 resume fall clears suspend", port_reg & 32'hC4, 32'h04);
    wr(32'h1084); wr(32'h10C4);
    check("R5 software resume no pulse", {30'd0, port_reg[6], pcd}, 32'd2);
    wr(32'h1004);
    wr(32'h1084); wr(32'h1184);
    check("R4 reset rise clears suspend", port_reg & 32'h184, 32'h100);
    hs = 1; wr(32'h1004); hs = 0;
    ls = 2'b01; step(); step();
    check("R9 K state reads 01", port_reg & 32'hC00, 32'h400);
    ls = 2'b10; step();
    check("R9 J state reads 10", port_reg & 32'hC00, 32'h800);
    connect = 0; step();
    check("R3 disconnect disables", port_reg & 32'hF, 32'hA);
    check("R11 pulse on disable", {31'd0, pcd}, 32'd1);
    wr(32'h100A);
    check("R3 W1C enable change", port_reg & 32'hA, 32'h0);
    oc = 1; step();
    check("R8 over-current set, power cut", port_reg & 32'h1030, 32'h30);
    check("R7 unpowered masks line state", port_reg & 32'hC00, 32'h0);
    wr(32'h0020);
    check("R8 W1C over-current change", {31'd0, port_reg[5]}, 32'd0);
    oc = 0; step();
    check("R8 over-current removal", port_reg & 32'h30, 32'h20);
    wr(32'h31000);
    check("R10 test mode 3", {28'd0, tmode}, 32'd3);
    wr(32'h71000);
    check("R10 reserved value ignored", {28'd0, port_reg[19:16]}, 32'd3);
    wr(32'h3000);
    check("R6 owner written", {31'd0, port_reg[13]}, 32'd1);
    connect = 1; step(); step();
    check("R11 no pulse while owner set", {30'd0, port_reg[1], pcd}, 32'd2);
    cfg = 0; step(); cfg = 1; step();
    check("R6 owner forced low on cfg rise", {31'd0, port_reg[13]}, 32'd0);
    model_cmp();
    // random phase
    for (int i = 0; i < 4000; i++) begin
      wr_en = ($urandom % 4) == 0;
      wr_data = $urandom;
      wr_data[12] = ($urandom % 8) != 0;
      wr_data[2]  = ($urandom % 4) != 0;
      wr_data[13] = ($urandom % 8) == 0;
      if (($urandom % 16) == 0) connect = ~connect;
      if (($urandom % 64) == 0) oc = ~oc;
      if (($urandom % 128) == 0) cfg = ~cfg;
      hs = $urandom; jk = ($urandom % 4) == 0; ls = $urandom;
      step();
      model_cmp();
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule